// File: doc/BRIEF.md
# Three-Wire Serial Register Access Controller

This block is a slave on a three-wire host link: an enable line, a serial clock and a data line. The data line is split into input, output and output-enable so that an I/O buffer at the chip edge can make it bidirectional. The serial pins are sampled by a fast system clock through synchronizers, and their edges are found by comparing successive samples. Every transfer opens with an 8-bit command that is shifted in least significant bit first. One byte, or a burst of bytes, then moves into or out of one of two address spaces.

The clock space has eight registers. Seven time registers belong to an external timekeeping block: they are read through a parallel bus and written through per-register write strobes. The eighth is a control register inside this block, whose top bit is a write-protect flag. The RAM space is a 24-byte scratch memory inside the block. Address 31 in either space selects a burst that starts at address 0. A clock-space burst write lands in a staging buffer and reaches the time registers all at once. A RAM burst write stores each byte as soon as it is complete.

Top module: `ser3_reg_ctrl`

## Requirements
- R1: When the enable line goes low, any transfer in progress is dropped. A byte that is not complete is not stored, and the output enable is low within three system clocks.
- R2: Command bit 0 selects read (1) or write (0). Bits 5:1 hold the address and bit 6 selects the RAM space (1) or the clock space (0). If bit 7 is 0, the rest of the transfer has no effect until the enable line drops.
- R3: Write data is taken on the rising serial-clock edges of the eight clocks after the command, bit 0 first. In byte mode, any later clocks in the same transfer are ignored.
- R4: Read data is driven bit 0 first on falling serial-clock edges. Bit 0 appears on the first falling edge after the eighth command bit.
- R5: In byte mode, a read that keeps clocking sends the same byte again, for as long as the enable line stays high.
- R6: Address 31 selects burst mode. A clock-space burst moves registers 0 to 7 in order, which is 72 clocks including the command. A RAM burst moves bytes 0 to 23 in order, which is 200 clocks including the command.
- R7: A clock-space burst write changes nothing unless all eight bytes arrive. When they do, all seven time-register strobes fire in the same system-clock cycle. A RAM burst write keeps every byte that was completed, even if the burst is cut short.
- R8: Clock addresses 8 to 30 and RAM addresses 24 to 30 have no storage. Reads from them return 0x00 and writes to them are discarded.
- R9: Control register bit 7 is write protect. While it is 1, writes to the time registers and to the RAM are blocked, but the control register itself can still be written. Control bits 6:0 always read 0.
- R10: The data output enable is high only during the data phase of a read whose command has bit 7 set.
- R11: A byte-mode write to time register n pulses only strobe n, for one system clock, with the byte on lane n of the write data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Transfer enable line, active high |
| sck_i | input | 1 | Serial clock from the host |
| sd_i | input | 1 | Serial data from the host |
| sd_o | output | 1 | Serial data to the host |
| sd_oe_o | output | 1 | Output enable for the data line |
| tm_rdata_i | input | N_TIME*8 | Current time-register values, byte n on lane n |
| tm_we_o | output | N_TIME | Per-register write strobes to the time block |
| tm_wdata_o | output | N_TIME*8 | Write data to the time block, byte n on lane n |

## Verification
The checker tests, on every cycle, properties that hold at the ports no matter what the host does. The output enable and the time-register strobes are never active unless the enable line was high three clocks earlier. A strobe lasts a single cycle. A strobe word is either one-hot or all ones. How the data itself behaves can only be shown by the bench's scenarios. These include the bit order, the repeated byte on a byte-mode read, the burst sequencing and its wrap, the all-or-nothing clock burst against the per-byte RAM burst, the empty addresses, write protect and aborted transfers. Each is checked by reading back through the serial port, or by watching the time block that the bench models, against a reference model of the registers.

// File: rtl/ser3_pkg.sv
package ser3_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_DATA = 2'd1,
    PH_SKIP = 2'd2
  } ph_t;

  localparam int CMD_BITS  = 8;
  localparam int ADDR_BITS = 5;
  localparam logic [ADDR_BITS-1:0] BURST_ADDR = '1;
endpackage

// File: rtl/ser3_pin_sync.sv
module ser3_pin_sync #(
  parameter int N_PINS = 3,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] lvl_o,
  output logic [N_PINS-1:0] rise_o,
  output logic [N_PINS-1:0] fall_o
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], pin_i[g]};
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign rise_o[g] = chain[STAGES-1] & ~chain[STAGES];
    assign fall_o[g] = ~chain[STAGES-1] & chain[STAGES];
  end
endmodule

// File: rtl/ser3_scratch_ram.sv
module ser3_scratch_ram #(
  parameter int DEPTH = 24,
  parameter int AW    = 5,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ser3_engine.sv
module ser3_engine
  import ser3_pkg::*;
#(
  parameter int N_TIME    = 7,
  parameter int RAM_DEPTH = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sel,
  input  logic                   sck_rise,
  input  logic                   sck_fall,
  input  logic                   sd_in,
  input  logic [N_TIME*8-1:0]    tm_rdata_i,
  input  logic [7:0]             ram_q,
  output logic                   ram_we,
  output logic [ADDR_BITS-1:0]   ram_waddr,
  output logic [7:0]             ram_wdata,
  output logic [ADDR_BITS-1:0]   ram_raddr,
  output logic                   sd_o,
  output logic                   sd_oe,
  output logic [N_TIME-1:0]      tm_we,
  output logic [N_TIME*8-1:0]    tm_wdata
);
  localparam int N_CLK = N_TIME + 1;
  localparam int IW    = $clog2(N_CLK);
  localparam logic [ADDR_BITS-1:0] TIME_CNT = ADDR_BITS'(N_TIME);
  localparam logic [ADDR_BITS-1:0] CTRL_A   = ADDR_BITS'(N_TIME);
  localparam logic [ADDR_BITS-1:0] RAM_CNT  = ADDR_BITS'(RAM_DEPTH);
  localparam logic [ADDR_BITS-1:0] RAM_LAST = ADDR_BITS'(RAM_DEPTH - 1);

  ph_t                   ph;
  logic [2:0]            bit_cnt;
  logic [7:0]            sr;
  logic                  is_rd, is_ram, is_burst;
  logic [ADDR_BITS-1:0]  idx;
  logic [1:0]            pend;
  logic [7:0]            tx_sr;
  logic                  wp;
  logic [N_TIME*8-1:0]   stage;
  logic [7:0]            full_byte;
  logic [7:0]            rd_byte;
  logic [IW-1:0]         idx_s;
  logic [ADDR_BITS-1:0]  rd_last;
  logic                  wr_done;

  assign full_byte = {sd_in, sr[7:1]};
  assign idx_s     = idx[IW-1:0];
  assign rd_last   = is_ram ? RAM_LAST : CTRL_A;
  assign wr_done   = sel && (ph == PH_DATA) && !is_rd && sck_rise && (bit_cnt == 3'd7);

  assign ram_we    = wr_done && is_ram && !wp && (idx < RAM_CNT);
  assign ram_waddr = idx;
  assign ram_wdata = full_byte;
  assign ram_raddr = idx;

  always_comb begin
    rd_byte = '0;
    if (is_ram) begin
      if (idx < RAM_CNT) rd_byte = ram_q;
    end else if (idx < TIME_CNT) begin
      rd_byte = tm_rdata_i[idx_s*8 +: 8];
    end else if (idx == CTRL_A) begin
      rd_byte = {wp, 7'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_CMD; bit_cnt <= '0; sr <= '0; is_rd <= 1'b0; is_ram <= 1'b0;
      is_burst <= 1'b0; idx <= '0; pend <= '0; tx_sr <= '0; wp <= 1'b0;
      stage <= '0; sd_o <= 1'b0; sd_oe <= 1'b0; tm_we <= '0; tm_wdata <= '0;
    end else begin
      tm_we <= '0;
      pend  <= {pend[0], 1'b0};
      sd_oe <= sel && (ph == PH_DATA) && is_rd;
      if (!sel) begin
        ph <= PH_CMD; bit_cnt <= '0; pend <= '0;
      end else begin
        if (pend[1]) tx_sr <= rd_byte;
        case (ph)
          PH_CMD: if (sck_rise) begin
            sr      <= full_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (full_byte[7]) begin
                ph       <= PH_DATA;
                is_rd    <= full_byte[0];
                is_ram   <= full_byte[6];
                is_burst <= (full_byte[5:1] == BURST_ADDR);
                idx      <= (full_byte[5:1] == BURST_ADDR) ? '0 : full_byte[5:1];
                pend     <= {pend[0], full_byte[0]};
              end else begin
                ph <= PH_SKIP;
              end
            end
          end
          PH_DATA: if (is_rd) begin
            if (sck_fall) begin
              sd_o    <= tx_sr[0];
              tx_sr   <= {1'b0, tx_sr[7:1]};
              bit_cnt <= bit_cnt + 3'd1;
              if (bit_cnt == 3'd7) begin
                if (is_burst) idx <= (idx == rd_last) ? '0 : idx + 1'b1;
                pend <= {pend[0], 1'b1};
              end
            end
          end else if (sck_rise) begin
            sr      <= full_byte;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (is_ram) begin
                if (!is_burst || idx == RAM_LAST) ph <= PH_SKIP;
                else idx <= idx + 1'b1;
              end else if (is_burst) begin
                if (idx < TIME_CNT) begin
                  stage[idx_s*8 +: 8] <= full_byte;
                end else begin
                  if (!wp) begin
                    tm_we    <= '1;
                    tm_wdata <= stage;
                  end
                  wp <= full_byte[7];
                  ph <= PH_SKIP;
                end
                idx <= idx + 1'b1;
              end else begin
                if (idx < TIME_CNT) begin
                  if (!wp) begin
                    tm_we[idx_s] <= 1'b1;
                    tm_wdata     <= {N_TIME{full_byte}};
                  end
                end else if (idx == CTRL_A) begin
                  wp <= full_byte[7];
                end
                ph <= PH_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ser3_reg_ctrl.sv
module ser3_reg_ctrl
  import ser3_pkg::*;
#(
  parameter int N_TIME      = 7,
  parameter int RAM_DEPTH   = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_i,
  input  logic                sck_i,
  input  logic                sd_i,
  output logic                sd_o,
  output logic                sd_oe_o,
  input  logic [N_TIME*8-1:0] tm_rdata_i,
  output logic [N_TIME-1:0]   tm_we_o,
  output logic [N_TIME*8-1:0] tm_wdata_o
);
  localparam int PINS = 3;

  logic [PINS-1:0] lvl, rise, fall;
  logic                 ram_we;
  logic [ADDR_BITS-1:0] ram_waddr, ram_raddr;
  logic [7:0]           ram_wdata, ram_q;

  ser3_pin_sync #(.N_PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_i({sd_i, sck_i, sel_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  ser3_scratch_ram #(.DEPTH(RAM_DEPTH), .AW(ADDR_BITS), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(ram_q)
  );

  ser3_engine #(.N_TIME(N_TIME), .RAM_DEPTH(RAM_DEPTH)) u_eng (
    .clk(clk), .rst(rst), .sel(lvl[0]), .sck_rise(rise[1]), .sck_fall(fall[1]),
    .sd_in(lvl[2]), .tm_rdata_i(tm_rdata_i), .ram_q(ram_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ram_raddr(ram_raddr), .sd_o(sd_o), .sd_oe(sd_oe_o),
    .tm_we(tm_we_o), .tm_wdata(tm_wdata_o)
  );

  logic unused_ok;
  assign unused_ok = ^{rise[0], fall[0], rise[2], fall[2]};
endmodule

// File: rtl/ser3_reg_ctrl_chk.sv
module ser3_reg_ctrl_chk #(
  parameter int N_TIME = 7
) (
  input logic                clk,
  input logic                rst,
  input logic                sel_i,
  input logic                sd_oe_o,
  input logic [N_TIME-1:0]   tm_we_o
);
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
    sd_oe_o |-> $past(sel_i, 3)); // R10
  AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (tm_we_o != '0) |-> $past(sel_i, 3)); // R1
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tm_we_o != '0) |=> (tm_we_o == '0)); // R11
  AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (tm_we_o != '0) |-> ($onehot0(tm_we_o) || (tm_we_o == '1))); // R7
endmodule

bind ser3_reg_ctrl ser3_reg_ctrl_chk #(.N_TIME(N_TIME)) u_chk (
  .clk(clk), .rst(rst), .sel_i(sel_i), .sd_oe_o(sd_oe_o), .tm_we_o(tm_we_o)
);

// File: tb/tb_ser3_reg_ctrl.sv
module tb_ser3_reg_ctrl;
  localparam int N_TIME = 7;
  localparam int H      = 8;

  logic clk = 1'b0, rst = 1'b1, sel = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic sdo, sdoe;
  logic [N_TIME*8-1:0] tm_q, tm_wd;
  logic [N_TIME-1:0]   tm_we;

  always #4 clk = ~clk;

  ser3_reg_ctrl dut (
    .clk(clk), .rst(rst), .sel_i(sel), .sck_i(sck), .sd_i(sdi),
    .sd_o(sdo), .sd_oe_o(sdoe), .tm_rdata_i(tm_q), .tm_we_o(tm_we), .tm_wdata_o(tm_wd)
  );

  // external time block: takes strobed lanes
  always_ff @(posedge clk) begin
    if (rst) tm_q <= '0;
    else for (int i = 0; i < N_TIME; i++) if (tm_we[i]) tm_q[i*8 +: 8] <= tm_wd[i*8 +: 8];
  end

  int errors = 0, checks = 0, oe_bad = 0, oe_seen = 0;
  bit done = 1'b0, rd_exp = 1'b0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];
  logic [7:0] m_ram [24];
  logic [7:0] m_tm [N_TIME];
  logic       m_wp = 1'b0;

  always @(negedge clk) if (!rst && sdoe) begin
    if (rd_exp) oe_seen++; else oe_bad++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mk(input bit rd, input bit ram, input int a);
    return {1'b1, ram, a[4:0], rd};
  endfunction

  function automatic logic [7:0] exp_clk(input int a);
    if (a < N_TIME) return m_tm[a];
    if (a == N_TIME) return {m_wp, 7'b0};
    return 8'h00;
  endfunction

  function automatic logic [7:0] exp_ram(input int a);
    return (a < 24) ? m_ram[a] : 8'h00;
  endfunction

  // one serial clock per bit: data set, rise, fall, then sample
  task automatic xfer(input logic [7:0] c, input int nbits, input bit keep_sel = 1'b0);
    rd_exp = c[7] & c[0];
    sel = 1'b1; tick(H);
    for (int i = 0; i < 8 + nbits; i++) begin
      logic b;
      b = (i < 8) ? c[i] : wbuf[(i-8)/8][(i-8)%8];
      sdi = b; tick(H);
      sck = 1'b1; tick(H);
      sck = 1'b0; tick(H);
      if (i >= 7 && (i-7) < 256) rbuf[(i-7)/8][(i-7)%8] = sdo;
    end
    if (!keep_sel) begin
      sel = 1'b0; tick(4*H); rd_exp = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL WATCHDOG (all requirements): actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < N_TIME; i++) m_tm[i] = 8'h00;
    tick(5); rst = 1'b0; tick(2);
    chk("R10 reset oe", {31'b0, sdoe}, 0);
    chk("R11 reset strobes", {25'b0, tm_we}, 0);

    // R6 RAM burst fill and read back
    for (int i = 0; i < 24; i++) begin wbuf[i] = 8'($urandom); m_ram[i] = wbuf[i]; end
    xfer(mk(0, 1, 31), 192);
    xfer(mk(1, 1, 31), 192);
    for (int i = 0; i < 24; i++) chk("R6 ram burst read", rbuf[i], m_ram[i]);

    // R7 full clock burst commits
    for (int i = 0; i < N_TIME; i++) wbuf[i] = 8'($urandom);
    wbuf[N_TIME] = 8'h00;
    xfer(mk(0, 0, 31), 64);
    for (int i = 0; i < N_TIME; i++) m_tm[i] = wbuf[i];
    for (int i = 0; i < N_TIME; i++) chk("R7 clock burst commit", tm_q[i*8 +: 8], m_tm[i]);
    xfer(mk(1, 0, 31), 64);
    for (int i = 0; i < 8; i++) chk("R6 clock burst read", rbuf[i], exp_clk(i));

    // R7 short clock burst changes nothing
    for (int i = 0; i < 5; i++) wbuf[i] = ~m_tm[i];
    xfer(mk(0, 0, 31), 40);
    for (int i = 0; i < N_TIME; i++) chk("R7 partial clock burst", tm_q[i*8 +: 8], m_tm[i]);

    // R7 short RAM burst keeps completed bytes
    for (int i = 0; i < 3; i++) begin wbuf[i] = ~m_ram[i]; m_ram[i] = wbuf[i]; end
    xfer(mk(0, 1, 31), 28);
    for (int a = 0; a < 4; a++) begin
      xfer(mk(1, 1, a), 8);
      chk("R7 partial ram burst", rbuf[0], m_ram[a]);
    end

    // random byte-mode traffic: R3 R4 R5 R8 R11
    for (int k = 0; k < 30; k++) begin
      bit sp, nost;
      int a;
      logic [7:0] v;
      sp = 1'($urandom % 2);
      nost = ($urandom % 5) == 0;
      if (sp) a = nost ? 24 + int'($urandom % 7) : int'($urandom % 24);
      else    a = nost ? 8 + int'($urandom % 23) : int'($urandom % N_TIME);
      v = 8'($urandom);
      wbuf[0] = v; wbuf[1] = ~v;
      xfer(mk(0, sp, a), 16);
      if (!nost) begin
        if (sp) m_ram[a] = v; else m_tm[a] = v;
      end
      if (!sp && !nost) chk("R11 time strobe lane", tm_q[a*8 +: 8], m_tm[a]);
      xfer(mk(1, sp, a), 16);
      if (nost) chk("R8 empty address", rbuf[0], 8'h00);
      else      chk("R3 R4 byte read", rbuf[0], sp ? exp_ram(a) : exp_clk(a));
      chk("R5 repeated byte", rbuf[1], rbuf[0]);
    end

    // R2 command without bit 7
    wbuf[0] = ~m_ram[5];
    xfer({1'b0, 1'b1, 5'd5, 1'b0}, 8);
    xfer({1'b0, 1'b1, 5'd5, 1'b1}, 16);
    xfer(mk(1, 1, 5), 8);
    chk("R2 invalid command ignored", rbuf[0], m_ram[5]);

    // R1 abort of a write and of a read
    wbuf[0] = ~m_ram[6];
    xfer(mk(0, 1, 6), 4);
    xfer(mk(1, 1, 6), 8);
    chk("R1 aborted write", rbuf[0], m_ram[6]);
    xfer(mk(1, 1, 6), 4, 1'b1);
    sel = 1'b0; tick(4);
    chk("R1 oe released", {31'b0, sdoe}, 0);
    tick(4*H); rd_exp = 1'b0;

    // R9 write protect
    wbuf[0] = 8'hFF;
    xfer(mk(0, 0, N_TIME), 8);
    m_wp = 1'b1;
    xfer(mk(1, 0, N_TIME), 8);
    chk("R9 control readback", rbuf[0], 8'h80);
    wbuf[0] = ~m_ram[2];
    xfer(mk(0, 1, 2), 8);
    xfer(mk(1, 1, 2), 8);
    chk("R9 ram blocked", rbuf[0], m_ram[2]);
    wbuf[0] = ~m_tm[3];
    xfer(mk(0, 0, 3), 8);
    chk("R9 time blocked", tm_q[3*8 +: 8], m_tm[3]);
    for (int i = 0; i < N_TIME; i++) wbuf[i] = ~m_tm[i];
    wbuf[N_TIME] = 8'h00;
    xfer(mk(0, 0, 31), 64);
    m_wp = 1'b0;
    for (int i = 0; i < N_TIME; i++) chk("R9 burst blocked", tm_q[i*8 +: 8], m_tm[i]);
    xfer(mk(1, 0, N_TIME), 8);
    chk("R9 protect cleared", rbuf[0], 8'h00);
    wbuf[0] = 8'h3C; m_ram[2] = 8'h3C;
    xfer(mk(0, 1, 2), 8);
    xfer(mk(1, 1, 2), 8);
    chk("R9 ram writable again", rbuf[0], 8'h3C);

    chk("R10 oe outside reads", oe_bad, 0);
    chk("R10 oe during reads", {31'b0, oe_seen > 0}, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule